// File: doc/BRIEF.md
# Reconfigurable NTT Butterfly Unit

This block is the arithmetic core of a number-theoretic-transform engine over a prime modulus `Q`. It performs one decimation-in-time butterfly per accepted input. The second input is multiplied by an operand picked by a two-bit mode. The product is then added to and subtracted from the first input, modulo `Q`. The multiplier uses Montgomery reduction with `R = 2^DW`, so every product carries a factor `R^-1 mod Q`. Twiddles and scaling constants are expected to be stored pre-multiplied by `R`.

The same hardware serves three jobs. In forward mode it takes the forward twiddle. In inverse mode it takes the inverse twiddle. In product mode it takes a separate multiplicand and ignores the first input, which gives pointwise products and coefficient scaling. A valid flag travels with the data, so the unit accepts a new pair on every cycle. Memory addressing and stage sequencing sit outside the block.

Top module: `ntt_bfly`

## Requirements
- R1: Every input sampled with `in_vld` high produces exactly one result with `out_vld` high 6 clock cycles later, in input order. One input may be accepted per cycle.
- R2: With `in_mode` = 2'b00, the operand is `in_tw_fwd`. Let `P = in_b * in_tw_fwd * R^-1 mod Q`. Then `out_sum = (in_a + P) mod Q` and `out_dif = (in_a - P) mod Q`.
- R3: With `in_mode` = 2'b01, the operand is `in_tw_inv`, and both outputs follow the formulas of R2 with that operand.
- R4: With `in_mode[1]` = 1 (2'b10 or 2'b11), `in_a` has no effect. Both `out_sum` and `out_dif` equal `in_b * in_alt * R^-1 mod Q`.
- R5: When all data inputs are below `Q`, both outputs and the internal product lie in [0, Q).
- R6: While reset is asserted and right after it is released, `out_vld` is 0 and both outputs are 0.
- R7: A cycle with `in_vld` low produces no result, whatever its data and mode inputs hold.
- R8: The modular sum has `Q` removed when it reaches `Q`. The modular difference has `Q` added when it goes negative. This holds at the edge operand values 0 and Q-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input pair is valid this cycle |
| in_mode | input | 2 | 00 forward, 01 inverse, 1x product |
| in_a | input | DW | First butterfly input (X0) |
| in_b | input | DW | Second butterfly input (X1), always multiplied |
| in_tw_fwd | input | DW | Forward twiddle, Montgomery form |
| in_tw_inv | input | DW | Inverse twiddle, Montgomery form |
| in_alt | input | DW | Multiplicand for product mode |
| out_vld | output | 1 | Result valid |
| out_sum | output | DW | X0 + operand product mod Q |
| out_dif | output | DW | X0 - operand product mod Q (the product in product mode) |

## Verification
The range properties assume that every data word presented with `in_vld` high is already reduced below `Q`. The Montgomery step only yields a value in [0, Q) when its input product is below `Q*R`. The stimulus draws all operands modulo `Q` and places the extremes 0 and Q-1 on each input in every mode. Garbage words are sent only in bubble cycles, where the latency and no-result rules still apply.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;

  typedef enum logic [1:0] {
    MODE_FWD   = 2'b00,
    MODE_INV   = 2'b01,
    MODE_PROD  = 2'b10,
    MODE_PROD2 = 2'b11
  } bfly_mode_e;

  // inverse of an odd value modulo 2^bits, by Newton iteration
  function automatic int unsigned inv_pow2(input int unsigned q, input int bits);
    int unsigned inv;
    inv = q;
    for (int i = 0; i < 5; i++) inv = inv * (32'd2 - q * inv);
    if (bits < 32) inv = inv & ((32'd1 << bits) - 32'd1);
    return inv;
  endfunction

  // a, b already in [0, q)
  function automatic int unsigned add_mod(input int unsigned a, input int unsigned b,
                                          input int unsigned q);
    int unsigned s;
    s = a + b;
    return (s >= q) ? s - q : s;
  endfunction

  function automatic int unsigned sub_mod(input int unsigned a, input int unsigned b,
                                          input int unsigned q);
    return (a >= b) ? a - b : a + q - b;
  endfunction

endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH+1];
  assign stage[0] = d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g+1] <= '0;
      else        stage[g+1] <= stage[g];
    end
  end

  assign q = stage[DEPTH];
endmodule

// File: rtl/bfly_opsel.sv
module bfly_opsel
  import ntt_bfly_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [1:0]    in_mode,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_tw_fwd,
  input  logic [DW-1:0] in_tw_inv,
  input  logic [DW-1:0] in_alt,
  output logic          sel_vld,
  output logic          sel_pw,
  output logic [DW-1:0] sel_x0,
  output logic [DW-1:0] sel_mul_a,
  output logic [DW-1:0] sel_mul_b
);
  logic [DW-1:0] operand;
  logic          prod_mode;

  always_comb begin
    prod_mode = in_mode[1];
    unique case (bfly_mode_e'(in_mode))
      MODE_FWD: operand = in_tw_fwd;
      MODE_INV: operand = in_tw_inv;
      default:  operand = in_alt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld   <= 1'b0;
      sel_pw    <= 1'b0;
      sel_x0    <= '0;
      sel_mul_a <= '0;
      sel_mul_b <= '0;
    end else begin
      sel_vld   <= in_vld;
      sel_pw    <= in_vld & prod_mode;
      sel_x0    <= (in_vld && !prod_mode) ? in_a : '0;
      sel_mul_a <= in_vld ? in_b : '0;
      sel_mul_b <= in_vld ? operand : '0;
    end
  end
endmodule

// File: rtl/bfly_montmul.sv
module bfly_montmul
  import ntt_bfly_pkg::*;
#(
  parameter int          DW = 16,
  parameter int unsigned Q  = 12289
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mul_a,
  input  logic [DW-1:0] mul_b,
  output logic [DW-1:0] mul_res
);
  localparam int unsigned QINV   = inv_pow2(Q, DW);
  localparam logic [DW-1:0] Q_V    = Q[DW-1:0];
  localparam logic [DW-1:0] QINV_V = QINV[DW-1:0];
  localparam logic [DW-1:0] ZERO   = '0;

  logic [2*DW-1:0] z_r;
  logic [DW-1:0]   t_r, th_r, zh_d;
  logic [2*DW-1:0] t_full, tq_full;
  logic [DW:0]     diff;

  // stage 1: full product
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) z_r <= '0;
    else        z_r <= {ZERO, mul_a} * {ZERO, mul_b};
  end

  // high half waits for the two reduction stages
  bfly_delay #(.W(DW), .DEPTH(2)) u_zh_dly (
    .clk(clk), .rst_n(rst_n), .d(z_r[2*DW-1:DW]), .q(zh_d)
  );

  // stage 2: T = z_low * q^-1 mod R
  assign t_full = {ZERO, z_r[DW-1:0]} * {ZERO, QINV_V};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_r <= '0;
    else        t_r <= t_full[DW-1:0];
  end

  // stage 3: high half of T * q
  assign tq_full = {ZERO, t_r} * {ZERO, Q_V};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) th_r <= '0;
    else        th_r <= tq_full[2*DW-1:DW];
  end

  // stage 4: zh - Th, lifted by q when negative, registered result
  assign diff = {1'b0, zh_d} - {1'b0, th_r};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mul_res <= '0;
    else if (diff[DW]) mul_res <= diff[DW-1:0] + Q_V;
    else              mul_res <= diff[DW-1:0];
  end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
  import ntt_bfly_pkg::*;
#(
  parameter int          DW = 16,
  parameter int unsigned Q  = 12289
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_vld,
  input  logic          fin_pw,
  input  logic [DW-1:0] fin_x0,
  input  logic [DW-1:0] fin_prod,
  output logic          res_vld,
  output logic          res_pw,
  output logic [DW-1:0] res_sum,
  output logic [DW-1:0] res_dif
);
  int unsigned s_full, d_full;

  always_comb begin
    s_full = add_mod(32'(fin_x0), 32'(fin_prod), Q);
    d_full = sub_mod(32'(fin_x0), 32'(fin_prod), Q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_pw  <= 1'b0;
      res_sum <= '0;
      res_dif <= '0;
    end else begin
      res_vld <= fin_vld;
      res_pw  <= fin_pw;
      res_sum <= fin_vld ? s_full[DW-1:0] : '0;
      res_dif <= !fin_vld ? '0 : (fin_pw ? fin_prod : d_full[DW-1:0]);
    end
  end
endmodule

// File: rtl/ntt_bfly.sv
module ntt_bfly
  import ntt_bfly_pkg::*;
#(
  parameter int          DW = 16,
  parameter int unsigned Q  = 12289
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [1:0]    in_mode,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_tw_fwd,
  input  logic [DW-1:0] in_tw_inv,
  input  logic [DW-1:0] in_alt,
  output logic          out_vld,
  output logic [DW-1:0] out_sum,
  output logic [DW-1:0] out_dif
);
  localparam int MUL_LAT = 4;
  localparam int TAG_W   = DW + 2;

  logic          sel_vld, sel_pw;
  logic [DW-1:0] sel_x0, sel_mul_a, sel_mul_b;
  logic [DW-1:0] mul_res;
  logic [TAG_W-1:0] tag_d;
  logic          mul_vld, pw_fin, res_pw;
  logic [DW-1:0] x0_fin;

  bfly_opsel #(.DW(DW)) u_opsel (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .in_tw_fwd(in_tw_fwd), .in_tw_inv(in_tw_inv),
    .in_alt(in_alt), .sel_vld(sel_vld), .sel_pw(sel_pw), .sel_x0(sel_x0),
    .sel_mul_a(sel_mul_a), .sel_mul_b(sel_mul_b)
  );

  bfly_montmul #(.DW(DW), .Q(Q)) u_mul (
    .clk(clk), .rst_n(rst_n), .mul_a(sel_mul_a), .mul_b(sel_mul_b), .mul_res(mul_res)
  );

  // X0, product flag and valid ride alongside the multiplier
  bfly_delay #(.W(TAG_W), .DEPTH(MUL_LAT)) u_x0_dly (
    .clk(clk), .rst_n(rst_n), .d({sel_vld, sel_pw, sel_x0}), .q(tag_d)
  );
  assign mul_vld = tag_d[TAG_W-1];
  assign pw_fin  = tag_d[TAG_W-2];
  assign x0_fin  = tag_d[DW-1:0];

  bfly_addsub #(.DW(DW), .Q(Q)) u_addsub (
    .clk(clk), .rst_n(rst_n), .fin_vld(mul_vld), .fin_pw(pw_fin),
    .fin_x0(x0_fin), .fin_prod(mul_res), .res_vld(out_vld), .res_pw(res_pw),
    .res_sum(out_sum), .res_dif(out_dif)
  );
endmodule

// File: rtl/ntt_bfly_chk.sv
module ntt_bfly_chk #(
  parameter int          DW = 16,
  parameter int unsigned Q  = 12289
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          out_vld,
  input logic [DW-1:0] out_sum,
  input logic [DW-1:0] out_dif,
  input logic          mul_vld,
  input logic [DW-1:0] mul_res,
  input logic [DW-1:0] x0_fin,
  input logic          res_pw
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##6 out_vld);

  assert_out_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (32'(out_sum) < Q) && (32'(out_dif) < Q));

  assert_mul_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_vld |-> 32'(mul_res) < Q);

  assert_prod_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && res_pw) |-> out_sum == out_dif);

  // sum and difference add back to twice X0 (R2, R3)
  assert_pair_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !res_pw) |->
      ((32'(out_sum) + 32'(out_dif)) % Q) == ((2 * 32'($past(x0_fin))) % Q));
endmodule

bind ntt_bfly ntt_bfly_chk #(.DW(DW), .Q(Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld),
  .out_sum(out_sum), .out_dif(out_dif), .mul_vld(mul_vld), .mul_res(mul_res),
  .x0_fin(x0_fin), .res_pw(res_pw)
);

// File: tb/ntt_bfly_bench.sv
`timescale 1ns/1ps
module ntt_bfly_bench;
  localparam int          DW  = 16;
  localparam int unsigned Q   = 12289;
  localparam int          LAT = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [1:0]    in_mode = '0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_tw_fwd = '0, in_tw_inv = '0, in_alt = '0;
  logic          out_vld;
  logic [DW-1:0] out_sum, out_dif;

  ntt_bfly #(.DW(DW), .Q(Q)) u_ntt_bfly (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .in_tw_fwd(in_tw_fwd), .in_tw_inv(in_tw_inv),
    .in_alt(in_alt), .out_vld(out_vld), .out_sum(out_sum), .out_dif(out_dif)
  );

  always #4 clk = ~clk;

  typedef struct {
    longint sum;
    longint dif;
    int     issue;
    string  tag;
  } exp_t;

  exp_t   pending[$];
  int     total = 0;
  int     bad = 0;
  int     cyc = 0;
  longint rinv = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference: Montgomery product and butterfly, computed with plain integers
  function automatic longint mont(input longint x, input longint y);
    return ((x * y) % Q) * rinv % Q;
  endfunction

  task automatic send(input bit v, input int m, input longint a, input longint b,
                      input longint f, input longint i, input longint al);
    exp_t e;
    longint op, p;
    @(negedge clk);
    in_vld = v; in_mode = 2'(m);
    in_a = DW'(a); in_b = DW'(b); in_tw_fwd = DW'(f); in_tw_inv = DW'(i); in_alt = DW'(al);
    if (v) begin
      op = (m == 0) ? f : (m == 1) ? i : al;
      p  = mont(b, op);
      if (m >= 2) begin
        e.sum = p; e.dif = p; e.tag = "R4";
      end else begin
        e.sum = (a + p) % Q; e.dif = (a - p + Q) % Q;
        e.tag = (m == 0) ? "R2" : "R3";
      end
      if (a == 0 || a == Q-1 || b == 0 || b == Q-1) e.tag = {e.tag, "/R8"};
      e.issue = cyc;
      pending.push_back(e);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done && out_vld) begin
      if (pending.size() == 0) begin
        check(1'b0, "R7 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = pending.pop_front();
        check(cyc - e.issue == LAT, "R1 latency", cyc - e.issue, LAT);
        check(out_sum == e.sum, {e.tag, " sum"}, out_sum, e.sum);
        check(out_dif == e.dif, {e.tag, " dif"}, out_dif, e.dif);
        check(out_sum < Q && out_dif < Q, "R5 range", out_sum, Q - 1);
      end
    end
  end

  initial begin
    #(8ns * 200000);
    check(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint edges[3];
    for (longint k = 1; k < Q; k++) if ((k * 65536) % Q == 1) rinv = k;
    edges[0] = 0; edges[1] = Q - 1; edges[2] = 1;

    repeat (4) @(negedge clk);
    check(out_vld == 1'b0, "R6 vld in reset", out_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0 && out_sum == 0 && out_dif == 0, "R6 after reset", out_sum, 0);

    // edge operands in every mode, back to back
    for (int m = 0; m < 4; m++)
      for (int ia = 0; ia < 2; ia++)
        for (int ib = 0; ib < 3; ib++)
          for (int iw = 0; iw < 3; iw++)
            send(1'b1, m, edges[ia], edges[ib], edges[iw], edges[2-iw], edges[(iw+1)%3]);

    // bubbles with garbage data must give no result (R7)
    for (int k = 0; k < 8; k++)
      send(1'b0, k % 4, $urandom % Q, $urandom % Q, $urandom % Q, $urandom % Q, $urandom % Q);
    repeat (LAT + 2) @(negedge clk);
    check(pending.size() == 0, "R7 bubbles drained", pending.size(), 0);

    // random traffic, mixed modes, with random gaps
    for (int k = 0; k < 800; k++)
      send(($urandom % 4) != 0, $urandom % 4, $urandom % Q, $urandom % Q,
           $urandom % Q, $urandom % Q, $urandom % Q);

    send(1'b0, 0, 0, 0, 0, 0, 0);
    repeat (LAT + 4) @(negedge clk);
    check(pending.size() == 0, "R1 all results returned", pending.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule